// File: doc/BRIEF.md
# Command/Query Handshake Register Interface

This block is the host-facing register set of a module whose real work is done by an internal command engine. The host writes an opcode into a command register, and optionally an argument into a parameter register before that. It then watches a status word to learn when the command has been taken, when it has finished, whether it failed, and whether a query result is waiting. The engine side is a plain request/acknowledge port. The acknowledge carries an error flag, a result-valid flag and the result word.

The status flags form a validity chain. The command-ready flag qualifies DONE, and DONE qualifies the no-error and query-ready flags. The block changes a qualified flag only while its qualifier marks it as invalid, so a host that polls at any cycle never sees a stale combination. On acceptance, command-ready drops first and DONE follows one cycle later. On completion, the result flags settle first, then DONE rises, then command-ready rises.

The status word is read-only and shares its offset with a write-only control word. The control word holds the module in reset, masks the system-fail output, and enables responses in the A24 address space. After any reset the block runs a timed initialization and then samples a self-test result. A failed self-test leaves the module unusable and drives the system-fail line unless that line is masked.

Top module: `cmdq_hs_regif`

## Requirements
- R1: The status word, read at word address 1, carries command-ready at bit 0, query-ready at bit 1, passed at bit 2, initialized at bit 3, no-error at bit 6 and DONE at bit 7. Every other bit reads 1. Addresses 0 and 2 read as all ones.
- R2: A write to the command register (address 0) while command-ready is 1 clears command-ready on that clock edge. Writes to the command register or to the parameter register (address 2) while command-ready is 0 change nothing.
- R3: One cycle after command-ready clears, DONE clears and the engine request rises, presenting the stored opcode and parameter. The request stays high until the engine acknowledges.
- R4: On the acknowledge edge, no-error, query-ready and the response word are loaded. DONE rises on the next edge, and command-ready rises on the edge after that.
- R5: Reading the query-response register (address 3) returns the stored result and clears query-ready. Reading the status word has no side effect.
- R6: DONE changes only when command-ready was 0 in the previous cycle. No-error changes, and query-ready rises, only when DONE was 0 in the previous cycle.
- R7: No-error reads 0 after a command acknowledged with the error flag set, and reads 1 again after a later command that succeeds.
- R8: While the module is in reset, passed and initialized are both 0. During initialization passed is 1 and initialized is 0. After INIT_CYCLES cycles with a good self-test, both are 1, and DONE and command-ready then rise in that order.
- R9: Writing 1 to control bit 0 (address 1) holds the module in reset, with status 0xFF70, for as long as the bit stays 1. Writing 0 releases the module and restarts initialization.
- R10: A failed self-test clears passed and drives sys_fail high, unless control bit 1 is 1. The failure is cleared by the next reset.
- R11: Control bit 15 drives a24_en. All other control bits (2 to 14) have no effect on any output or on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe (side effects only) |
| bus_addr | input | 2 | Host word address |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| eng_req | output | 1 | Command pending for the engine |
| eng_opcode | output | 16 | Opcode of the pending command |
| eng_param | output | 16 | Parameter of the pending command |
| eng_ack | input | 1 | Engine finished the command |
| eng_err | input | 1 | Command failed (valid with eng_ack) |
| eng_qvalid | input | 1 | Command returns a query result (valid with eng_ack) |
| eng_qdata | input | 16 | Query result (valid with eng_ack and eng_qvalid) |
| selftest_ok | input | 1 | Self-test outcome, sampled at the end of initialization |
| mod_reset | output | 1 | Module held in reset by the control word |
| sys_fail | output | 1 | System-fail indication |
| a24_en | output | 1 | A24 address-space responses enabled |

## Verification
The assertions check the validity chain of R6 on every cycle: no DONE change unless command-ready was low, and no block-driven change to no-error or rise of query-ready unless DONE was low. They also check that command-ready clears after an accepted write, that it only rises behind DONE, that the engine request is seen only with both flags low, and that sys_fail and initialized imply the right value of passed. The bench scenarios are what show the exact cycle of each step in the accept and completion sequences, the returned query data, the ignored writes and control bits, the timing of a hold and its release, and the masking of the fail line.

// File: rtl/cqh_pkg.sv
package cqh_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 2;

    // Word addresses
    localparam logic [ADDR_W-1:0] A_CMD   = 2'd0;
    localparam logic [ADDR_W-1:0] A_STCTL = 2'd1;
    localparam logic [ADDR_W-1:0] A_PARAM = 2'd2;
    localparam logic [ADDR_W-1:0] A_QRESP = 2'd3;

    // Status bit positions (decoded by host software)
    localparam int ST_CMDRDY = 0;
    localparam int ST_QRDY   = 1;
    localparam int ST_PASSED = 2;
    localparam int ST_READY  = 3;
    localparam int ST_NOERR  = 6;
    localparam int ST_DONE   = 7;

    // Control bit positions
    localparam int CT_HOLD    = 0;
    localparam int CT_INHIBIT = 1;
    localparam int CT_A24     = 15;

    typedef struct packed {
        logic wr_cmd;
        logic wr_ctrl;
        logic wr_param;
        logic rd_query;
    } host_strb_t;

    typedef struct packed {
        logic done;
        logic noerr;
        logic ready;
        logic passed;
        logic q_rdy;
        logic cmd_rdy;
    } flags_t;

    typedef struct packed {
        logic hold;
        logic inhibit;
        logic a24;
    } ctrl_t;

    typedef enum logic [2:0] {
        S_RST,
        S_INIT,
        S_FAIL,
        S_IDLE,
        S_ACCEPT,
        S_BUSY,
        S_FIN,
        S_REARM
    } seq_st_t;

    function automatic logic [REG_W-1:0] pack_status(input flags_t f);
        logic [REG_W-1:0] w;
        w            = '1;
        w[ST_CMDRDY] = f.cmd_rdy;
        w[ST_QRDY]   = f.q_rdy;
        w[ST_PASSED] = f.passed;
        w[ST_READY]  = f.ready;
        w[ST_NOERR]  = f.noerr;
        w[ST_DONE]   = f.done;
        return w;
    endfunction

endpackage

// File: rtl/cqh_decode.sv
module cqh_decode
    import cqh_pkg::*;
(
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output host_strb_t        strb
);

    always_comb begin
        strb.wr_cmd   = bus_wr && (bus_addr == A_CMD);
        strb.wr_ctrl  = bus_wr && (bus_addr == A_STCTL);
        strb.wr_param = bus_wr && (bus_addr == A_PARAM);
        strb.rd_query = bus_rd && (bus_addr == A_QRESP);
    end

endmodule

// File: rtl/cqh_ctrl_reg.sv
module cqh_ctrl_reg
    import cqh_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  logic  hold_bit,
    input  logic  inhibit_bit,
    input  logic  a24_bit,
    output ctrl_t ctrl
);

    // Only the board reset clears the control word; the hold it carries
    // must survive the module reset it causes.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr) begin
            ctrl.hold    <= hold_bit;
            ctrl.inhibit <= inhibit_bit;
            ctrl.a24     <= a24_bit;
        end
    end

endmodule

// File: rtl/cqh_seq.sv
module cqh_seq
    import cqh_pkg::*;
#(
    parameter int INIT_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             wr_cmd,
    input  logic             wr_param,
    input  logic             rd_query,
    input  logic [REG_W-1:0] wdata,
    input  logic             selftest_ok,
    input  logic             eng_ack,
    input  logic             eng_err,
    input  logic             eng_qvalid,
    input  logic [REG_W-1:0] eng_qdata,
    output flags_t           flags,
    output logic             failed,
    output logic             eng_req,
    output logic [REG_W-1:0] opcode,
    output logic [REG_W-1:0] param,
    output logic [REG_W-1:0] qresp
);

    localparam int CNT_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYCLES - 1);

    seq_st_t          state;
    logic [CNT_W-1:0] cnt;

    assign eng_req = (state == S_BUSY);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            state         <= S_RST;
            flags.done    <= 1'b0;
            flags.noerr   <= 1'b1;
            flags.ready   <= 1'b0;
            flags.passed  <= 1'b0;
            flags.q_rdy   <= 1'b0;
            flags.cmd_rdy <= 1'b0;
            failed        <= 1'b0;
            cnt           <= '0;
            opcode        <= '0;
            param         <= '0;
            qresp         <= '0;
        end else begin
            // host-side clear; a completion in the same cycle wins below
            if (rd_query) flags.q_rdy <= 1'b0;
            if (wr_param && flags.cmd_rdy) param <= wdata;
            case (state)
                S_RST: begin
                    flags.passed <= 1'b1;
                    cnt          <= '0;
                    state        <= S_INIT;
                end
                S_INIT: begin
                    if (cnt == CNT_LAST) begin
                        if (selftest_ok) begin
                            flags.ready <= 1'b1;
                            state       <= S_FIN;
                        end else begin
                            flags.passed <= 1'b0;
                            failed       <= 1'b1;
                            state        <= S_FAIL;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_FAIL: state <= S_FAIL;
                S_IDLE: begin
                    if (wr_cmd) begin
                        flags.cmd_rdy <= 1'b0;
                        opcode        <= wdata;
                        state         <= S_ACCEPT;
                    end
                end
                S_ACCEPT: begin
                    flags.done <= 1'b0;
                    state      <= S_BUSY;
                end
                S_BUSY: begin
                    if (eng_ack) begin
                        flags.noerr <= !eng_err;
                        if (eng_qvalid) begin
                            flags.q_rdy <= 1'b1;
                            qresp       <= eng_qdata;
                        end
                        state <= S_FIN;
                    end
                end
                S_FIN: begin
                    flags.done <= 1'b1;
                    state      <= S_REARM;
                end
                S_REARM: begin
                    flags.cmd_rdy <= 1'b1;
                    state         <= S_IDLE;
                end
            endcase
        end
    end

    // R6: DONE moves only behind a low command-ready
    a_r6_done_gated: assert property (@(posedge clk) disable iff (rst || hold)
        !$stable(flags.done) |-> $past(!flags.cmd_rdy));

    // R6: no-error moves only behind a low DONE
    a_r6_noerr_gated: assert property (@(posedge clk) disable iff (rst || hold)
        !$stable(flags.noerr) |-> $past(!flags.done));

    // R6: query-ready is raised only behind a low DONE
    a_r6_qrdy_gated: assert property (@(posedge clk) disable iff (rst || hold)
        $rose(flags.q_rdy) |-> $past(!flags.done));

    // R2: an accepted command write drops command-ready
    a_r2_cmd_clears: assert property (@(posedge clk) disable iff (rst || hold)
        (wr_cmd && flags.cmd_rdy) |=> !flags.cmd_rdy);

    // R4: command-ready returns only after DONE is already up
    a_r4_rearm_after_done: assert property (@(posedge clk) disable iff (rst || hold)
        $rose(flags.cmd_rdy) |-> $past(flags.done));

    // R3: the engine is asked only while both handshake flags are low
    a_r3_req_flags_low: assert property (@(posedge clk) disable iff (rst || hold)
        eng_req |-> (!flags.done && !flags.cmd_rdy));

    // R8: initialized implies passed
    a_r8_ready_passed: assert property (@(posedge clk) disable iff (rst || hold)
        flags.ready |-> flags.passed);

endmodule

// File: rtl/cmdq_hs_regif.sv
module cmdq_hs_regif
    import cqh_pkg::*;
#(
    parameter int INIT_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              eng_req,
    output logic [REG_W-1:0]  eng_opcode,
    output logic [REG_W-1:0]  eng_param,
    input  logic              eng_ack,
    input  logic              eng_err,
    input  logic              eng_qvalid,
    input  logic [REG_W-1:0]  eng_qdata,
    input  logic              selftest_ok,
    output logic              mod_reset,
    output logic              sys_fail,
    output logic              a24_en
);

    host_strb_t       strb;
    ctrl_t            ctrl;
    flags_t           flags;
    logic             failed;
    logic [REG_W-1:0] qresp;

    cqh_decode u_decode (
        .bus_wr  (bus_wr),
        .bus_rd  (bus_rd),
        .bus_addr(bus_addr),
        .strb    (strb)
    );

    cqh_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr         (strb.wr_ctrl),
        .hold_bit   (bus_wdata[CT_HOLD]),
        .inhibit_bit(bus_wdata[CT_INHIBIT]),
        .a24_bit    (bus_wdata[CT_A24]),
        .ctrl       (ctrl)
    );

    cqh_seq #(.INIT_CYCLES(INIT_CYCLES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .hold       (ctrl.hold),
        .wr_cmd     (strb.wr_cmd),
        .wr_param   (strb.wr_param),
        .rd_query   (strb.rd_query),
        .wdata      (bus_wdata),
        .selftest_ok(selftest_ok),
        .eng_ack    (eng_ack),
        .eng_err    (eng_err),
        .eng_qvalid (eng_qvalid),
        .eng_qdata  (eng_qdata),
        .flags      (flags),
        .failed     (failed),
        .eng_req    (eng_req),
        .opcode     (eng_opcode),
        .param      (eng_param),
        .qresp      (qresp)
    );

    always_comb begin
        case (bus_addr)
            A_STCTL: bus_rdata = pack_status(flags);
            A_QRESP: bus_rdata = qresp;
            default: bus_rdata = '1;
        endcase
    end

    assign mod_reset = ctrl.hold;
    assign a24_en    = ctrl.a24;
    assign sys_fail  = failed && !ctrl.inhibit;

    // R10: the fail line is never raised while passed reads 1
    a_r10_fail_not_passed: assert property (@(posedge clk) disable iff (rst)
        sys_fail |-> !flags.passed);

    // R9: while held, the sequencer reports not passed one cycle in
    a_r9_hold_clears_passed: assert property (@(posedge clk) disable iff (rst)
        (mod_reset && $past(mod_reset)) |-> !flags.passed);

endmodule

// File: tb/cmdq_hs_regif_tb_top.sv
module cmdq_hs_regif_tb_top;
    import cqh_pkg::*;

    localparam int INIT_N = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              bus_wr, bus_rd;
    logic [ADDR_W-1:0] bus_addr;
    logic [REG_W-1:0]  bus_wdata, bus_rdata;
    logic              eng_req, eng_ack, eng_err, eng_qvalid;
    logic [REG_W-1:0]  eng_opcode, eng_param, eng_qdata;
    logic              selftest_ok, mod_reset, sys_fail, a24_en;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    cmdq_hs_regif #(.INIT_CYCLES(INIT_N)) dut_i (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_req(eng_req), .eng_opcode(eng_opcode), .eng_param(eng_param),
        .eng_ack(eng_ack), .eng_err(eng_err), .eng_qvalid(eng_qvalid),
        .eng_qdata(eng_qdata), .selftest_ok(selftest_ok),
        .mod_reset(mod_reset), .sys_fail(sys_fail), .a24_en(a24_en)
    );

    task automatic chk(input string rq, input logic [REG_W-1:0] act,
                       input logic [REG_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // all bus tasks start and end at a falling edge
    task automatic host_write(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic host_read(input logic [ADDR_W-1:0] a, output logic [REG_W-1:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read_status(output logic [REG_W-1:0] d);
        host_read(A_STCTL, d);
    endtask

    task automatic eng_finish(input logic err, input logic qv, input logic [REG_W-1:0] qd);
        eng_ack = 1'b1; eng_err = err; eng_qvalid = qv; eng_qdata = qd;
        @(negedge clk);
        eng_ack = 1'b0; eng_err = 1'b0; eng_qvalid = 1'b0;
    endtask

    task automatic wait_status(input string rq, input logic [REG_W-1:0] exp, input int max);
        logic [REG_W-1:0] s;
        s = '0;
        for (int i = 0; i < max; i++) begin
            read_status(s);
            if (s == exp) break;
        end
        chk(rq, s, exp);
    endtask

    task automatic t_reset_init;
        logic [REG_W-1:0] s;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        read_status(s);
        chk("R8 reset status", s, 16'hFF70);
        chk("R9 mod_reset after reset", {15'd0, mod_reset}, 16'd0);
        chk("R11 a24_en after reset", {15'd0, a24_en}, 16'd0);
        chk("R3 no request after reset", {15'd0, eng_req}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        read_status(s);
        chk("R8 init in progress", s, 16'hFF74);
        wait_status("R8 init complete", 16'hFFFD, 3 * INIT_N);
        host_read(A_CMD, s);
        chk("R1 command address reads ones", s, 16'hFFFF);
        host_read(A_PARAM, s);
        chk("R1 parameter address reads ones", s, 16'hFFFF);
    endtask

    task automatic t_cmd_query;
        logic [REG_W-1:0] s;
        host_write(A_PARAM, 16'h00A5);
        host_write(A_CMD, 16'h0042);
        read_status(s);
        chk("R2 cmd_rdy clears on write", s, 16'hFFFC);
        read_status(s);
        chk("R3 DONE clears next cycle", s, 16'hFF7C);
        chk("R3 request raised", {15'd0, eng_req}, 16'd1);
        chk("R3 opcode presented", eng_opcode, 16'h0042);
        chk("R3 parameter presented", eng_param, 16'h00A5);
        repeat (3) @(negedge clk);
        chk("R3 request held until ack", {15'd0, eng_req}, 16'd1);
        eng_finish(1'b0, 1'b1, 16'h1234);
        read_status(s);
        chk("R4 result flags first", s, 16'hFF7E);
        chk("R4 request dropped on ack", {15'd0, eng_req}, 16'd0);
        read_status(s);
        chk("R4 DONE second", s, 16'hFFFE);
        read_status(s);
        chk("R4 cmd_rdy third", s, 16'hFFFF);
        read_status(s);
        chk("R5 status read has no side effect", s, 16'hFFFF);
        host_read(A_QRESP, s);
        chk("R5 query data", s, 16'h1234);
        read_status(s);
        chk("R5 query read clears q_rdy", s, 16'hFFFD);
    endtask

    task automatic t_ignored_writes;
        logic [REG_W-1:0] s;
        host_write(A_PARAM, 16'h0005);
        host_write(A_CMD, 16'h0011);
        @(negedge clk);
        host_write(A_CMD, 16'hBEEF);
        host_write(A_PARAM, 16'hDEAD);
        chk("R2 command write ignored while busy", eng_opcode, 16'h0011);
        chk("R2 parameter write ignored while busy", eng_param, 16'h0005);
        read_status(s);
        chk("R2 flags unchanged by ignored writes", s, 16'hFF7C);
        eng_finish(1'b0, 1'b0, 16'h0000);
        wait_status("R2 ignored command not run", 16'hFFFD, 4);
        chk("R2 no second request", {15'd0, eng_req}, 16'd0);
    endtask

    task automatic t_error;
        logic [REG_W-1:0] s;
        host_write(A_CMD, 16'h0077);
        @(negedge clk);
        eng_finish(1'b1, 1'b0, 16'h0000);
        read_status(s);
        chk("R7 no-error low before DONE", s, 16'hFF3C);
        wait_status("R7 error reported", 16'hFFBD, 4);
        host_write(A_CMD, 16'h0078);
        @(negedge clk);
        eng_finish(1'b0, 1'b0, 16'h0000);
        wait_status("R7 no-error restored", 16'hFFFD, 4);
    endtask

    task automatic t_ctrl_bits;
        logic [REG_W-1:0] s;
        host_write(A_STCTL, 16'h8000);
        chk("R11 a24 enabled", {15'd0, a24_en}, 16'd1);
        chk("R11 bit 15 no hold", {15'd0, mod_reset}, 16'd0);
        host_write(A_STCTL, 16'h7FFC);
        chk("R11 a24 disabled", {15'd0, a24_en}, 16'd0);
        chk("R11 unused bits no hold", {15'd0, mod_reset}, 16'd0);
        read_status(s);
        chk("R11 unused bits leave status", s, 16'hFFFD);
    endtask

    task automatic t_hold_fail;
        logic [REG_W-1:0] s;
        int bad;
        host_write(A_STCTL, 16'h0001);
        chk("R9 mod_reset asserted", {15'd0, mod_reset}, 16'd1);
        read_status(s);
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            read_status(s);
            if (s != 16'hFF70) bad++;
        end
        chk("R9 held reset status", s, 16'hFF70);
        chk("R9 hold stable count", 16'(bad), 16'd0);
        selftest_ok = 1'b0;
        host_write(A_STCTL, 16'h0000);
        chk("R9 released", {15'd0, mod_reset}, 16'd0);
        for (int i = 0; i < 3 * INIT_N; i++) begin
            if (sys_fail) break;
            @(negedge clk);
        end
        chk("R10 sys_fail on failed self-test", {15'd0, sys_fail}, 16'd1);
        read_status(s);
        chk("R10 passed low after failure", s, 16'hFF70);
        host_write(A_STCTL, 16'h0002);
        chk("R10 inhibit masks sys_fail", {15'd0, sys_fail}, 16'd0);
        host_write(A_STCTL, 16'h0000);
        chk("R10 unmask restores sys_fail", {15'd0, sys_fail}, 16'd1);
        selftest_ok = 1'b1;
        host_write(A_STCTL, 16'h0001);
        @(negedge clk);
        host_write(A_STCTL, 16'h0000);
        read_status(s);
        chk("R9 still reset on release edge", s, 16'hFF70);
        read_status(s);
        chk("R9 init restarts", s, 16'hFF74);
        wait_status("R9 recovered", 16'hFFFD, 3 * INIT_N);
        chk("R10 failure cleared by reset", {15'd0, sys_fail}, 16'd0);
    endtask

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        eng_ack = 1'b0; eng_err = 1'b0; eng_qvalid = 1'b0; eng_qdata = '0;
        selftest_ok = 1'b1;
        @(negedge clk);
        t_reset_init();
        t_cmd_query();
        t_ignored_writes();
        t_error();
        t_ctrl_bits();
        t_hold_fail();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule